// File: doc/BRIEF.md
# Paced Serial Byte Transmitter with Chaining Handshake

This block drives bytes onto one asynchronous serial output line. A programmable tick count sets the bit time. A one-cycle start request launches a frame. Every frame begins with one bit time of high level, which acts as a leading stop interval, and then a low start bit. The data bits follow, least significant first. Because of this ordering, the start edge is clean whatever level the line held before.

Bytes can be sent back to back. While a frame is early enough to accept more work, the `ready` output is high. During that time the user may present the next byte with a chain request, which sets a pending flag. When the final data bit of the frame is on the line, `ready` drops. At the end of that bit the block checks the pending flag. If it is set, the stored byte is sent at once, again preceded by its own stop interval and start bit. If it is clear, the line is left high and a sticky completion flag is raised. The flag stays set until it is cleared by a strobe.

Top module: `paced_serial_tx`

## Requirements
- R1: After reset the line is high, and `busy`, `ready`, `chain_pending` and `tx_done` are all low.
- R2: A start request while idle captures `byte_in`. The line is then high for one bit time, low for one bit time, and then carries the data bits least significant bit first, each for one bit time.
- R3: One bit time equals `bit_period` clock cycles, and a value of 0 is taken as 1. The period is captured when a start request is accepted and applies to every frame chained from it, so a frame of N data bits keeps `busy` high for (N+2) bit times.
- R4: With `short_frame`=1 at the start request, a frame carries 7 data bits (`byte_in[6:0]`). With `short_frame`=0 it carries 8. The setting applies to chained frames as well.
- R5: `ready` is high while the stop interval, the start bit and every data bit except the last are on the line. It is low during the last data bit and while idle.
- R6: A chain request in a cycle with `ready` high stores `byte_in` as the next byte and sets `chain_pending`. A chain request while `ready` is low has no effect: no extra frame follows.
- R7: When the last data bit ends with `chain_pending` set, the next frame starts in the following cycle with its stop interval and the stored byte. `chain_pending` is cleared and `ready` is high again.
- R8: When the last data bit ends with `chain_pending` clear, `busy` falls, the line stays high and `tx_done` is set.
- R9: `tx_done` stays set until a `done_clr` pulse clears it. If the completion and the clear happen in the same cycle, the set takes priority.
- R10: A start request while `busy` is high is ignored. The current frame and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_period | input | 16 | Bit time in clock cycles (0 acts as 1) |
| short_frame | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| start_req | input | 1 | One-cycle request to begin a frame |
| byte_in | input | 8 | Byte for a start or chain request |
| chain_req | input | 1 | One-cycle request to queue the next byte |
| done_clr | input | 1 | Clears the completion flag |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is being sent |
| ready | output | 1 | A chain request is accepted this cycle |
| chain_pending | output | 1 | A next byte is queued |
| tx_done | output | 1 | Sticky completion flag |

## Verification
The assertions assume that the request inputs are single-cycle pulses sampled on the rising edge. They also assume that `bit_period` and `short_frame` matter only in the cycle a start request is accepted, so the bound on the tick counter relies on the captured copy and not on the live input. The stimulus changes inputs only on falling edges. It gives start requests while idle and while busy, and chain requests both in the accepting window and in the last data bit. It uses periods of 0, 1, 2 and 3 so that the one-cycle bit and the end-of-frame cases coincide in some runs.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  typedef enum logic {PH_IDLE = 1'b0, PH_SEND = 1'b1} phase_t;

  // index of the final data bit: slot 0 = stop interval, slot 1 = start bit
  function automatic int unsigned last_pos(input logic short_sel, input int unsigned data_w);
    return short_sel ? data_w : data_w + 1;
  endfunction

  // terminal count of the tick counter for a requested period (0 behaves as 1)
  function automatic logic [31:0] tick_limit(input logic [31:0] per);
    return (per == 32'd0) ? 32'd0 : per - 32'd1;
  endfunction

endpackage

// File: rtl/ptx_bit_timer.sv
module ptx_bit_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] limit,
  output logic                bit_end
);
  logic [PERIOD_W-1:0] cnt_q;

  assign bit_end = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || bit_end)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + PERIOD_W'(1);
  end

  // tick counter never passes the captured terminal count (R3)
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

endmodule

// File: rtl/ptx_handshake.sv
module ptx_handshake #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              last_bit,
  input  logic              frame_end,
  input  logic              start_go,
  input  logic              chain_req,
  input  logic              done_clr,
  input  logic [DATA_W-1:0] byte_in,
  output logic              ready,
  output logic              sev,
  output logic [DATA_W-1:0] next_byte,
  output logic              done
);
  logic              sev_q;
  logic              done_q;
  logic [DATA_W-1:0] next_q;
  logic              chain_take;

  assign ready      = run && !last_bit;
  assign chain_take = chain_req && ready;
  assign sev        = sev_q;
  assign next_byte  = next_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sev_q  <= 1'b0;
      next_q <= '0;
    end else if (start_go || frame_end) begin
      sev_q  <= 1'b0;
    end else if (chain_take) begin
      sev_q  <= 1'b1;
      next_q <= byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  done_q <= 1'b0;
    else if (frame_end && !sev_q) done_q <= 1'b1;
    else if (done_clr)            done_q <= 1'b0;
  end

  // a chain request outside the window leaves the stored byte alone (R6)
  assert_chain_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chain_req && !ready |=> $stable(next_q));

  // accepted chain request is visible as pending next cycle (R6)
  assert_chain_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chain_req && ready |=> sev_q);

  // completion flag persists until a clear strobe (R9)
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !done_clr |=> done_q);

endmodule

// File: rtl/paced_serial_tx.sv
module paced_serial_tx
  import ptx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] bit_period,
  input  logic                short_frame,
  input  logic                start_req,
  input  logic [DATA_W-1:0]   byte_in,
  input  logic                chain_req,
  input  logic                done_clr,
  output logic                tx_line,
  output logic                busy,
  output logic                ready,
  output logic                chain_pending,
  output logic                tx_done
);
  localparam int POS_W = $clog2(DATA_W + 2);

  phase_t              phase_q;
  logic [POS_W-1:0]    pos_q;
  logic [DATA_W-1:0]   shreg_q;
  logic [PERIOD_W-1:0] limit_q;
  logic                short_q;

  logic                run;
  logic                bit_end;
  logic                start_go;
  logic                last_bit;
  logic                frame_end;
  logic [POS_W-1:0]    last_idx;
  logic [DATA_W-1:0]   next_byte;

  assign run       = (phase_q == PH_SEND);
  assign last_idx  = POS_W'(last_pos(short_q, DATA_W));
  assign start_go  = start_req && !run;
  assign last_bit  = run && (pos_q == last_idx);
  assign frame_end = last_bit && bit_end;
  assign busy      = run;

  ptx_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .limit   (limit_q),
    .bit_end (bit_end)
  );

  ptx_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .last_bit  (last_bit),
    .frame_end (frame_end),
    .start_go  (start_go),
    .chain_req (chain_req),
    .done_clr  (done_clr),
    .byte_in   (byte_in),
    .ready     (ready),
    .sev       (chain_pending),
    .next_byte (next_byte),
    .done      (tx_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pos_q   <= '0;
      shreg_q <= '0;
      limit_q <= '0;
      short_q <= 1'b0;
    end else if (start_go) begin
      phase_q <= PH_SEND;
      pos_q   <= '0;
      shreg_q <= byte_in;
      limit_q <= PERIOD_W'(tick_limit(32'(bit_period)));
      short_q <= short_frame;
    end else if (bit_end) begin
      if (frame_end) begin
        pos_q <= '0;
        if (chain_pending) shreg_q <= next_byte;
        else               phase_q <= PH_IDLE;
      end else begin
        pos_q <= pos_q + POS_W'(1);
        if (pos_q >= POS_W'(2)) shreg_q <= shreg_q >> 1;
      end
    end
  end

  always_comb begin
    if (!run)                   tx_line = 1'b1;
    else if (pos_q == '0)       tx_line = 1'b1;
    else if (pos_q == POS_W'(1)) tx_line = 1'b0;
    else                        tx_line = shreg_q[0];
  end

  // an accepted start opens with the stop interval (R2)
  assert_start_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (run && pos_q == '0 && tx_line));

  // frame position never runs past the selected length (R4)
  assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_q <= last_idx));

  // pending byte follows immediately with a fresh stop interval (R7)
  assert_chain_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && chain_pending |=> (run && pos_q == '0 && !chain_pending
                                    && shreg_q == $past(next_byte)));

  // no pending byte: line released high and completion raised (R8)
  assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !chain_pending |=> (!run && tx_line && tx_done));

  // start while busy disturbs nothing (R10)
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && run && !bit_end |=> ($stable(pos_q) && $stable(shreg_q) && $stable(limit_q)));

endmodule

// File: tb/sim_paced_serial_tx.sv
`timescale 1ns/1ps
module sim_paced_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bit_period = 16'd3;
  logic        short_frame = 1'b0;
  logic        start_req = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        chain_req = 1'b0;
  logic        done_clr = 1'b0;
  logic        tx_line, busy, ready, chain_pending, tx_done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int busy_cycles = 0;

  always #2 clk = ~clk;

  paced_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .short_frame(short_frame),
    .start_req(start_req), .byte_in(byte_in), .chain_req(chain_req), .done_clr(done_clr),
    .tx_line(tx_line), .busy(busy), .ready(ready), .chain_pending(chain_pending), .tx_done(tx_done)
  );

  // ---------------- behavioural reference: a queue of line levels ----------------
  bit       m_q[$];
  int       m_left, m_per;
  bit       m_busy, m_sev, m_done, m_short;
  logic [7:0] m_next;

  function automatic void m_load(input logic [7:0] b);
    m_q.delete();
    m_q.push_back(1'b1);
    m_q.push_back(1'b0);
    for (int i = 0; i < (m_short ? 7 : 8); i++) m_q.push_back(b[i]);
    m_left = m_per;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_busy = 0; m_sev = 0; m_done = 0;
      m_left = 0; m_per = 1; m_next = 8'h00; m_short = 0;
    end else begin
      bit rdy, be, fe, go, sev0;
      rdy  = m_busy && (m_q.size() > 1);
      be   = m_busy && (m_left == 1);
      fe   = be && (m_q.size() == 1);
      go   = start_req && !m_busy;
      sev0 = m_sev;
      if (chain_req && rdy) begin m_next = byte_in; m_sev = 1; end
      if (fe && !sev0) m_done = 1;
      else if (done_clr) m_done = 0;
      if (go) begin
        m_per = (bit_period == 16'd0) ? 1 : int'(bit_period);
        m_short = short_frame;
        m_load(byte_in);
        m_busy = 1; m_sev = 0;
      end else if (be) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin
          if (sev0) begin m_load(m_next); m_sev = 0; end
          else m_busy = 0;
        end else m_left = m_per;
      end else if (m_busy) begin
        m_left--;
      end
    end
  end

  task automatic cmp(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp(tx_line,       m_busy ? m_q[0] : 1'b1,           "R2 line level");
      cmp(busy,          m_busy,                            "R8 busy");
      cmp(ready,         m_busy && (m_q.size() > 1),        "R5 ready");
      cmp(chain_pending, m_sev,                             "R6 pending");
      cmp(tx_done,       m_done,                            "R9 done");
      if (busy) busy_cycles++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pulse_start(input logic [7:0] b, input logic [15:0] p, input logic sh);
    @(negedge clk);
    busy_cycles = 0;
    byte_in = b; bit_period = p; short_frame = sh; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic pulse_chain(input logic [7:0] b);
    byte_in = b; chain_req = 1'b1;
    @(negedge clk);
    chain_req = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic clear_done;
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_line, 1, "R1 line idle high");
    chk(busy + ready + chain_pending + tx_done, 0, "R1 flags low");

    // R2/R3: stop interval then start bit, period 3
    pulse_start(8'hA5, 16'd3, 1'b0);
    n = 0;
    while (tx_line) begin n++; @(negedge clk); end
    chk(n, 3, "R2 stop interval length");
    n = 0;
    while (!tx_line) begin n++; @(negedge clk); end
    chk(n, 3, "R2 start bit length");
    wait_idle();
    chk(busy_cycles, 30, "R3 8-bit frame length at period 3");
    chk(tx_done, 1, "R8 done after lone frame");
    repeat (4) @(negedge clk);
    chk(tx_done, 1, "R9 done held without clear");
    clear_done();
    chk(tx_done, 0, "R9 done cleared by strobe");

    // R3: period 0 behaves as 1
    pulse_start(8'h5A, 16'd0, 1'b0);
    n = 0;
    while (tx_line) begin n++; @(negedge clk); end
    chk(n, 1, "R3 period zero as one");
    wait_idle();
    chk(busy_cycles, 10, "R3 frame length at period 0");
    clear_done();

    // R4: short frame
    pulse_start(8'hFF, 16'd2, 1'b1);
    wait_idle();
    chk(busy_cycles, 18, "R4 7-bit frame length");
    clear_done();

    // R7: chained byte follows at once
    pulse_start(8'h3C, 16'd2, 1'b0);
    pulse_chain(8'hC3);
    chk(chain_pending, 1, "R6 chain accepted while ready");
    wait_idle();
    chk(busy_cycles, 40, "R7 two back-to-back frames");
    chk(chain_pending, 0, "R7 pending cleared");
    clear_done();

    // R6: chain during last data bit is ignored
    pulse_start(8'h81, 16'd2, 1'b0);
    while (!(busy && !ready)) @(negedge clk);
    pulse_chain(8'h11);
    wait_idle();
    chk(busy_cycles, 20, "R6 late chain adds no frame");
    chk(tx_done, 1, "R6 frame completes alone");
    clear_done();

    // R10: start while busy ignored
    pulse_start(8'h0F, 16'd2, 1'b0);
    repeat (5) @(negedge clk);
    start_req = 1'b1; byte_in = 8'hF0; bit_period = 16'd7;
    @(negedge clk);
    start_req = 1'b0;
    wait_idle();
    chk(busy_cycles, 20, "R10 restart ignored while busy");
    clear_done();

    // R9: set beats clear in same cycle; period 1 with chained short frames
    pulse_start(8'h66, 16'd1, 1'b1);
    pulse_chain(8'h19);
    while (busy) begin done_clr = 1'b1; @(negedge clk); end
    done_clr = 1'b0;
    chk(tx_done, 1, "R9 set wins over clear");
    chk(busy_cycles, 18, "R7 chained short frames at period 1");
    clear_done();

    // mixed traffic, compared every cycle against the reference
    for (int k = 0; k < 6; k++) begin
      pulse_start(8'(k * 37 + 5), 16'(k % 4), 1'(k % 2));
      if (k % 3 != 2) pulse_chain(8'(k * 91 + 3));
      wait_idle();
      clear_done();
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule